// File: doc/BRIEF.md
# Thermal Fault Mode Controller

This block supervises the operating mode of a bus transceiver chip that carries two groups of temperature sensors. The core group watches the transceiver and the supply regulator. The driver group watches the high-side switch and the limp-home output. Each sensor group delivers one over-temperature flag. The flags arrive already debounced, with hysteresis applied. From these flags, from a wake event, from the control-mode strap (pin or SPI) and from a fail-safe disable bit, the block drives the transmitter, the regulator, the reset line, the switch enables, two sticky interrupt flags and the current mode.

The two groups get different responses. A core fault acts at once: it forces the transmitter recessive, turns the regulator off and pulls reset low. On the next clock it moves the mode machine into FAILSAFE or SLEEP. The machine leaves FAILSAFE on a wake event. If the fault has cleared by then, the machine passes through RESTART back to NORMAL. If the fault is still present, the machine drops into SLEEP. A driver fault only gates off the switch and limp-home enables while it lasts, and it never changes the mode.

The machine has four states. NORMAL is the state after reset. A core fault moves NORMAL to FAILSAFE, or to SLEEP when SPI mode has fail-safe disabled. From FAILSAFE, a wake with the fault cleared goes to RESTART, and a wake with the fault still present goes to SLEEP. From SLEEP, a wake with the fault cleared goes to RESTART. RESTART returns to NORMAL after a set number of cycles; a core fault during RESTART is handled the same way as a core fault in NORMAL.

Top module: `thermal_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode output reads NORMAL, both interrupt flags read 0, the regulator is enabled and reset is released. The mode codes are NORMAL=0, SLEEP=1, FAILSAFE=2, RESTART=3.
- R2: Whenever the core fault flag is high, in the same cycle, tx_recessive is 1, vreg_en is 0 and rst_low is 1.
- R3: While the mode is FAILSAFE or SLEEP, rst_low stays 1 and vreg_en stays 0 even after the core flag clears. tx_recessive is 1 in every mode other than NORMAL.
- R4: While the driver fault flag is high, hss_en and limp_en are 0 in the same cycle, and the mode does not change. When the flag drops, each enable follows its request again.
- R5: In pin control mode (spi_mode=0), a core fault seen in NORMAL or RESTART moves the mode to FAILSAFE on the next cycle.
- R6: In SPI mode with fs_dis=0, a core fault moves the mode to FAILSAFE on the next cycle. While the mode is FAILSAFE in SPI mode, limp_en is 1 unless the driver fault is present.
- R7: In SPI mode with fs_dis=1, a core fault moves the mode to SLEEP on the next cycle.
- R8: In FAILSAFE, a wake with the core flag low moves the mode to RESTART, and a wake with the core flag high moves it to SLEEP. Without a wake the mode stays FAILSAFE.
- R9: In SLEEP, a wake with the core flag low moves the mode to RESTART. Otherwise the mode stays SLEEP.
- R10: RESTART lasts RESTART_HOLD cycles and then returns to NORMAL.
- R11: In SPI mode, a core fault sets irq_core (bit 0) and a driver fault sets irq_drv (bit 1), visible one cycle after the flag is sampled. In pin mode neither flag is set.
- R12: A 1 on irq_clr bit 0 clears irq_core and a 1 on bit 1 clears irq_drv. A clear strobe has no effect while the matching fault is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ot_core | input | 1 | Transceiver/regulator over-temperature flag |
| ot_drv | input | 1 | High-side switch/limp-home over-temperature flag |
| wake | input | 1 | Wake event |
| spi_mode | input | 1 | 1 = SPI control, 0 = pin control |
| fs_dis | input | 1 | Fail-safe disable (SPI mode); 0 after reset of its register |
| hss_req | input | 1 | High-side switch on request |
| limp_req | input | 1 | Limp-home on request |
| irq_clr | input | 2 | Write-one-to-clear strobes, bit0 core, bit1 driver |
| tx_recessive | output | 1 | Force transmitter recessive |
| vreg_en | output | 1 | Supply regulator enable |
| rst_low | output | 1 | Drive reset line low |
| hss_en | output | 1 | High-side switch enable |
| limp_en | output | 1 | Limp-home output enable |
| irq_core | output | 1 | Sticky core thermal interrupt |
| irq_drv | output | 1 | Sticky driver thermal interrupt |
| mode | output | 3 | Current mode code |

## Verification
The bench builds the block with RESTART_HOLD=3. With that value the RESTART dwell counter has to step through more than one value, so an off-by-one in the dwell length shows up as a wrong mode in a specific cycle. The bench sweeps all four combinations of strap and fail-safe disable through a full fault, hold, wake and restart cycle, computing the destination mode and the interrupt state arithmetically from the two bits. It also sweeps all sixteen combinations of switch requests, driver fault and strap, and it walks the wake-while-faulted path from FAILSAFE through SLEEP.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    typedef enum logic [2:0] {
        M_NORMAL   = 3'd0,
        M_SLEEP    = 3'd1,
        M_FAILSAFE = 3'd2,
        M_RESTART  = 3'd3
    } tmc_mode_e;

    localparam int IRQ_N    = 2;
    localparam int IRQ_CORE = 0;
    localparam int IRQ_DRV  = 1;
endpackage

// File: rtl/tmc_mode_fsm.sv
module tmc_mode_fsm
    import tmc_pkg::*;
#(
    parameter int RESTART_HOLD = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ot_core,
    input  logic      wake,
    input  logic      spi_mode,
    input  logic      fs_dis,
    output tmc_mode_e mode_q
);
    localparam int CW = (RESTART_HOLD > 1) ? $clog2(RESTART_HOLD) : 1;

    tmc_mode_e         mode_d;
    tmc_mode_e         fault_dest;
    logic [CW-1:0]     cnt_q;
    logic              hold_done;

    assign fault_dest = (spi_mode && fs_dis) ? M_SLEEP : M_FAILSAFE;
    assign hold_done  = (cnt_q == CW'(RESTART_HOLD - 1));

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_NORMAL: begin
                if (ot_core) mode_d = fault_dest;
            end
            M_RESTART: begin
                if (ot_core)        mode_d = fault_dest;
                else if (hold_done) mode_d = M_NORMAL;
            end
            M_FAILSAFE: begin
                if (wake) mode_d = ot_core ? M_SLEEP : M_RESTART;
            end
            M_SLEEP: begin
                if (wake && !ot_core) mode_d = M_RESTART;
            end
            default: mode_d = M_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_NORMAL;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            if (mode_q == M_RESTART && mode_d == M_RESTART)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    // R5
    pin_fault_to_fs_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_NORMAL && ot_core && !spi_mode) |=> mode_q == M_FAILSAFE);
    // R7
    spi_nofs_to_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_NORMAL && ot_core && spi_mode && fs_dis) |=> mode_q == M_SLEEP);
    // R8
    fs_wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_FAILSAFE && wake && !ot_core) |=> mode_q == M_RESTART);
    // R8
    fs_wake_hot_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_FAILSAFE && wake && ot_core) |=> mode_q == M_SLEEP);
    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_SLEEP && !(wake && !ot_core)) |=> mode_q == M_SLEEP);
endmodule

// File: rtl/tmc_irq_flags.sv
module tmc_irq_flags
    import tmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_mode,
    input  logic [IRQ_N-1:0] fault,
    input  logic [IRQ_N-1:0] clr,
    output logic [IRQ_N-1:0] flag_q
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (spi_mode && fault[i])
                flag_q[i] <= 1'b1;
            else if (clr[i] && !fault[i])
                flag_q[i] <= 1'b0;
        end

        // R11
        irq_set_chk: assert property (@(posedge clk) disable iff (rst)
            (spi_mode && fault[i]) |=> flag_q[i]);
        // R12
        irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && fault[i]) |=> flag_q[i]);
        // R11
        irq_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!spi_mode && !flag_q[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/tmc_out_drive.sv
module tmc_out_drive
    import tmc_pkg::*;
(
    input  tmc_mode_e mode_q,
    input  logic      ot_core,
    input  logic      ot_drv,
    input  logic      spi_mode,
    input  logic      hss_req,
    input  logic      limp_req,
    output logic      tx_recessive,
    output logic      vreg_en,
    output logic      rst_low,
    output logic      hss_en,
    output logic      limp_en
);
    logic parked;
    logic fs_limp;

    always_comb begin
        parked       = (mode_q == M_FAILSAFE) || (mode_q == M_SLEEP);
        fs_limp      = spi_mode && (mode_q == M_FAILSAFE);
        tx_recessive = ot_core || (mode_q != M_NORMAL);
        rst_low      = ot_core || parked;
        vreg_en      = !(ot_core || parked);
        hss_en       = hss_req && !ot_drv;
        limp_en      = (limp_req || fs_limp) && !ot_drv;
    end
endmodule

// File: rtl/thermal_mode_ctrl.sv
module thermal_mode_ctrl
    import tmc_pkg::*;
#(
    parameter int RESTART_HOLD = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ot_core,
    input  logic       ot_drv,
    input  logic       wake,
    input  logic       spi_mode,
    input  logic       fs_dis,
    input  logic       hss_req,
    input  logic       limp_req,
    input  logic [1:0] irq_clr,
    output logic       tx_recessive,
    output logic       vreg_en,
    output logic       rst_low,
    output logic       hss_en,
    output logic       limp_en,
    output logic       irq_core,
    output logic       irq_drv,
    output logic [2:0] mode
);
    tmc_mode_e        mode_q;
    logic [IRQ_N-1:0] fault_v;
    logic [IRQ_N-1:0] flag_v;

    assign fault_v[IRQ_CORE] = ot_core;
    assign fault_v[IRQ_DRV]  = ot_drv;

    tmc_mode_fsm #(.RESTART_HOLD(RESTART_HOLD)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ot_core  (ot_core),
        .wake     (wake),
        .spi_mode (spi_mode),
        .fs_dis   (fs_dis),
        .mode_q   (mode_q)
    );

    tmc_irq_flags u_irq (
        .clk      (clk),
        .rst      (rst),
        .spi_mode (spi_mode),
        .fault    (fault_v),
        .clr      (irq_clr),
        .flag_q   (flag_v)
    );

    tmc_out_drive u_out (
        .mode_q       (mode_q),
        .ot_core      (ot_core),
        .ot_drv       (ot_drv),
        .spi_mode     (spi_mode),
        .hss_req      (hss_req),
        .limp_req     (limp_req),
        .tx_recessive (tx_recessive),
        .vreg_en      (vreg_en),
        .rst_low      (rst_low),
        .hss_en       (hss_en),
        .limp_en      (limp_en)
    );

    assign mode     = mode_q;
    assign irq_core = flag_v[IRQ_CORE];
    assign irq_drv  = flag_v[IRQ_DRV];

    // R2
    core_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        ot_core |-> (tx_recessive && rst_low && !vreg_en));
    // R4
    drv_mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ot_drv && !ot_core && mode == 3'd0) |=> mode == 3'd0);
    // R3
    parked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2 && !wake) |=> (rst_low && !vreg_en));
endmodule

// File: tb/tb_thermal_mode_ctrl.sv
module tb_thermal_mode_ctrl;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst, ot_core, ot_drv, wake, spi_mode, fs_dis, hss_req, limp_req;
    logic [1:0] irq_clr;
    logic tx_recessive, vreg_en, rst_low, hss_en, limp_en, irq_core, irq_drv;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    thermal_mode_ctrl #(.RESTART_HOLD(HOLD)) dut (
        .clk(clk), .rst(rst), .ot_core(ot_core), .ot_drv(ot_drv), .wake(wake),
        .spi_mode(spi_mode), .fs_dis(fs_dis), .hss_req(hss_req),
        .limp_req(limp_req), .irq_clr(irq_clr), .tx_recessive(tx_recessive),
        .vreg_en(vreg_en), .rst_low(rst_low), .hss_en(hss_en),
        .limp_en(limp_en), .irq_core(irq_core), .irq_drv(irq_drv), .mode(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; ot_core = 0; ot_drv = 0; wake = 0; spi_mode = 0; fs_dis = 0;
        hss_req = 0; limp_req = 0; irq_clr = 2'b00;
        step(); step();
        rst = 0;
        #1;
        chk("R1 mode", mode, 0);
        chk("R1 irq_core", irq_core, 0);
        chk("R1 irq_drv", irq_drv, 0);
        chk("R1 vreg_en", vreg_en, 1);
        chk("R1 rst_low", rst_low, 0);

        // core fault sweep over strap and fail-safe disable
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 2; f++) begin
                int dest;
                dest = (s == 1 && f == 1) ? 1 : 2;
                spi_mode = s[0]; fs_dis = f[0];
                ot_core = 1;
                #1;
                chk("R2 tx_recessive", tx_recessive, 1);
                chk("R2 vreg_en", vreg_en, 0);
                chk("R2 rst_low", rst_low, 1);
                step();
                chk(s == 0 ? "R5 dest" : (f == 0 ? "R6 dest" : "R7 dest"), mode, dest);
                chk("R11 irq_core", irq_core, s);
                chk("R6 limp_en", limp_en, (s == 1 && dest == 2) ? 1 : 0);
                irq_clr = 2'b01;
                step();
                chk("R12 clear ignored while hot", irq_core, s);
                irq_clr = 2'b00;
                ot_core = 0;
                step();
                chk("R3 mode held", mode, dest);
                chk("R3 rst_low held", rst_low, 1);
                chk("R3 vreg_en held", vreg_en, 0);
                chk("R3 tx_recessive", tx_recessive, 1);
                wake = 1;
                step();
                wake = 0;
                for (int k = 0; k < HOLD; k++) begin
                    chk(dest == 2 ? "R8 restart" : "R9 restart", mode, 3);
                    chk("R3 tx in restart", tx_recessive, 1);
                    step();
                end
                chk("R10 back to normal", mode, 0);
                chk("R10 rst_low", rst_low, 0);
                chk("R10 tx released", tx_recessive, 0);
                irq_clr = 2'b01;
                step();
                irq_clr = 2'b00;
                chk("R12 clear", irq_core, 0);
            end
        end

        // wake while fault still present, pin mode
        spi_mode = 0; fs_dis = 0;
        ot_core = 1;
        step();
        chk("R5 failsafe", mode, 2);
        step();
        chk("R8 no wake stays", mode, 2);
        wake = 1;
        step();
        chk("R8 wake hot to sleep", mode, 1);
        step();
        chk("R9 wake hot stays sleep", mode, 1);
        wake = 0; ot_core = 0;
        step();
        chk("R9 no wake stays", mode, 1);
        chk("R3 sleep rst_low", rst_low, 1);
        wake = 1;
        step();
        wake = 0;
        chk("R9 sleep to restart", mode, 3);
        // fault during restart
        ot_core = 1;
        step();
        chk("R5 restart fault", mode, 2);
        ot_core = 0; wake = 1;
        step();
        wake = 0;
        for (int k = 0; k < HOLD; k++) step();
        chk("R10 normal again", mode, 0);

        // driver fault sweep
        for (int v = 0; v < 16; v++) begin
            hss_req = v[0]; limp_req = v[1]; ot_drv = v[2]; spi_mode = v[3];
            #1;
            chk("R4 hss_en", hss_en, (v[0] && !v[2]) ? 1 : 0);
            chk("R4 limp_en", limp_en, (v[1] && !v[2]) ? 1 : 0);
            step();
            chk("R4 mode unchanged", mode, 0);
            chk("R11 irq_drv", irq_drv, (v[2] && v[3]) ? 1 : 0);
            ot_drv = 0; irq_clr = 2'b10;
            step();
            irq_clr = 2'b00;
            chk("R12 irq_drv clear", irq_drv, 0);
            chk("R4 hss_en restored", hss_en, v[0]);
        end

        // SPI failsafe limp with driver fault
        hss_req = 0; limp_req = 0; spi_mode = 1; fs_dis = 0;
        ot_core = 1;
        step();
        ot_core = 0; ot_drv = 1;
        #1;
        chk("R6 limp gated by drv fault", limp_en, 0);
        step();
        ot_drv = 0;
        #1;
        chk("R6 limp in failsafe", limp_en, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule